// File: doc/BRIEF.md
# Serial Bit-Rate Tick Generator

This block derives the bit-rate timing for an asynchronous serial controller. It starts from the core clock. A fixed divider makes an internal bus-rate enable at one quarter of the core clock. A configuration byte then picks one of four non-binary prescale ratios (1, 3, 4 or 13) and a binary rate stage that divides by 2 raised to a 3-bit exponent. A final divide by sixteen turns the oversample rate into the bit rate. The block outputs a one-core-cycle bit tick and, if the option is built in, a one-cycle tick at sixteen times the bit rate.

The configuration byte sits behind a byte-wide write strobe and a read bus that shows it at all times. Every write resets all the divider counters. The first period after a write is therefore a full period at the new setting. The reset value depends on two mode inputs: in bootstrap mode the byte is preset to a slow default, and otherwise it clears to the fastest setting. Two test bits and one spare bit are stored and read back but change no timing.

Top module: `baud_rate_gen`

## Requirements
- R1: While `rst_n` is low with `boot_sel` low, the configuration byte resets to 0x00, which gives a bit period of 64 core cycles.
- R2: When `boot_sel` is high and `mode_a` is low during reset, the byte resets to 0x33, which gives a bit period of 6656 core cycles. When `mode_a` is also high, the byte resets to 0x00.
- R3: `rd_data` always shows the last byte written, in all eight bits, and it changes only on a write or a reset.
- R4: Bits 5:4 select the prescale ratio: 00 selects 1, 01 selects 3, 10 selects 4, and 11 selects 13.
- R5: Bits 2:0 hold an exponent n from 0 to 7, and the binary stage divides by 2^n.
- R6: The bit period in core cycles is 4 × prescale × 16 × 2^n.
- R7: A write accepted at a clock edge restarts every counter. No tick is output in the cycle after that edge, and the first bit tick is high in core cycle N−1 after that edge, where N is the new period.
- R8: `os_tick` pulses exactly 16 times in each bit period, and one of those pulses falls in the same cycle as `bit_tick`.
- R9: Bits 7, 6 and 3 do not affect the timing.
- R10: `bit_tick` is high for exactly one core cycle per period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_sel | input | 1 | Special-mode strap, sampled while reset is active |
| mode_a | input | 1 | Mode-A strap; when high it cancels the bootstrap preset |
| wr_en | input | 1 | Write strobe for the configuration byte |
| wr_data | input | 8 | Byte to be written |
| rd_data | output | 8 | Current configuration byte |
| os_tick | output | 1 | One-cycle pulse at sixteen times the bit rate |
| bit_tick | output | 1 | One-cycle pulse at the bit rate |

## Verification
The bench walks every prescale code and several exponents, up to the slowest binary setting. For each one it checks both the first-tick delay after the write and the steady period. If a non-binary ratio were decoded wrongly, the period would come out at a multiple of 64 core cycles that the formula does not give. If a write failed to restart the counters, the first tick after a rewrite would come early, because part of the old period would be left over. Writes with the test and spare bits set confirm that those bits are read back but leave the period unchanged. Reset is run with both straps high and with only the bootstrap strap high, which catches a mode decode that ignores the mode-A input.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;

   localparam int CFG_W   = 8;
   localparam int RATE_W  = 3;
   localparam int PRE_W   = 4;
   localparam int RCNT_W  = (1 << RATE_W) - 1;

   typedef struct packed {
      logic       test_hi;
      logic       spare;
      logic [1:0] pre_sel;
      logic       test_lo;
      logic [2:0] rate_sel;
   } baud_cfg_t;

   function automatic logic [PRE_W-1:0] prescale_of(input logic [1:0] code);
      logic [PRE_W-1:0] r;
      case (code)
         2'b00:   r = 4'd1;
         2'b01:   r = 4'd3;
         2'b10:   r = 4'd4;
         default: r = 4'd13;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/baud_bus_en.sv
module baud_bus_en #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic bus_en
);
   localparam int W = (DIV > 2) ? $clog2(DIV) : 1;
   localparam logic [W-1:0] LAST = W'(DIV - 1);

   generate
      if (DIV < 2) begin : g_bad_div
         $error("baud_bus_en: DIV must be at least 2");
      end
   endgenerate

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (restart)      cnt <= '0;
      else if (cnt == LAST)  cnt <= '0;
      else                   cnt <= cnt + 1'b1;
   end

   assign bus_en = (cnt == LAST);

   // R6: the bus-rate enable never lasts two core cycles
   a_r6_bus_gap: assert property (@(posedge clk) disable iff (!rst_n)
      bus_en |=> !bus_en);

endmodule

// File: rtl/baud_cfg_reg.sv
module baud_cfg_reg
   import baud_gen_pkg::*;
#(
   parameter logic [CFG_W-1:0] BOOT_VALUE = 8'h33
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             boot_sel,
   input  logic             mode_a,
   input  logic             wr_en,
   input  logic [CFG_W-1:0] wr_data,
   output baud_cfg_t        cfg
);
   logic [CFG_W-1:0] reset_val;
   assign reset_val = (boot_sel && !mode_a) ? BOOT_VALUE : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg <= baud_cfg_t'(reset_val);
      else if (wr_en)  cfg <= baud_cfg_t'(wr_data);
   end

   // R3: a write is visible whole on the next cycle
   a_r3_readback: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (cfg == baud_cfg_t'($past(wr_data))));

   // R3: without a write the byte holds
   a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(cfg));

endmodule

// File: rtl/baud_divider.sv
module baud_divider
   import baud_gen_pkg::*;
#(
   parameter int OS_RATIO = 16,
   parameter bit OS_EN    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              bus_en,
   input  logic [1:0]        pre_sel,
   input  logic [RATE_W-1:0] rate_sel,
   output logic              os_tick,
   output logic              bit_tick
);
   localparam int OS_W = (OS_RATIO > 2) ? $clog2(OS_RATIO) : 1;
   localparam logic [OS_W-1:0] OS_LAST = OS_W'(OS_RATIO - 1);

   generate
      if (OS_RATIO < 2) begin : g_bad_os
         $error("baud_divider: OS_RATIO must be at least 2");
      end
   endgenerate

   logic [PRE_W-1:0]  pre_cnt, pre_max;
   logic [RCNT_W-1:0] rate_cnt, rate_max;
   logic [OS_W-1:0]   os_cnt;
   logic              pre_tick, rate_tick;

   assign pre_max   = prescale_of(pre_sel) - 1'b1;
   assign rate_max  = RCNT_W'((1 << rate_sel) - 1);
   assign pre_tick  = bus_en && (pre_cnt == pre_max);
   assign rate_tick = pre_tick && (rate_cnt == rate_max);
   assign bit_tick  = rate_tick && (os_cnt == OS_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pre_cnt <= '0;
      else if (restart)  pre_cnt <= '0;
      else if (bus_en)   pre_cnt <= (pre_cnt == pre_max) ? '0 : pre_cnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         rate_cnt <= '0;
      else if (restart)   rate_cnt <= '0;
      else if (pre_tick)  rate_cnt <= (rate_cnt == rate_max) ? '0 : rate_cnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          os_cnt <= '0;
      else if (restart)    os_cnt <= '0;
      else if (rate_tick)  os_cnt <= (os_cnt == OS_LAST) ? '0 : os_cnt + 1'b1;
   end

   generate
      if (OS_EN) begin : g_os_on
         assign os_tick = rate_tick;
      end else begin : g_os_off
         assign os_tick = 1'b0;
      end
   endgenerate

   // R4: the prescale count never passes the selected ratio
   a_r4_pre_bound: assert property (@(posedge clk) disable iff (!rst_n)
      pre_cnt <= pre_max);

   // R5: the rate count never passes 2^n - 1
   a_r5_rate_bound: assert property (@(posedge clk) disable iff (!rst_n)
      rate_cnt <= rate_max);

endmodule

// File: rtl/baud_rate_gen.sv
module baud_rate_gen
   import baud_gen_pkg::*;
#(
   parameter int               BUS_DIV    = 4,
   parameter int               OS_RATIO   = 16,
   parameter bit               OS_EN      = 1'b1,
   parameter logic [CFG_W-1:0] BOOT_VALUE = 8'h33
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             boot_sel,
   input  logic             mode_a,
   input  logic             wr_en,
   input  logic [CFG_W-1:0] wr_data,
   output logic [CFG_W-1:0] rd_data,
   output logic             os_tick,
   output logic             bit_tick
);
   baud_cfg_t cfg;
   logic      bus_en;

   baud_cfg_reg #(.BOOT_VALUE(BOOT_VALUE)) cfg_i (
      .clk(clk), .rst_n(rst_n), .boot_sel(boot_sel), .mode_a(mode_a),
      .wr_en(wr_en), .wr_data(wr_data), .cfg(cfg));

   baud_bus_en #(.DIV(BUS_DIV)) bus_i (
      .clk(clk), .rst_n(rst_n), .restart(wr_en), .bus_en(bus_en));

   baud_divider #(.OS_RATIO(OS_RATIO), .OS_EN(OS_EN)) div_i (
      .clk(clk), .rst_n(rst_n), .restart(wr_en), .bus_en(bus_en),
      .pre_sel(cfg.pre_sel), .rate_sel(cfg.rate_sel),
      .os_tick(os_tick), .bit_tick(bit_tick));

   assign rd_data = cfg;

   // R7: a write leaves no tick in the following cycle
   a_r7_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (!bit_tick && !os_tick));

   // R10: the bit tick is a single-cycle pulse
   a_r10_bit_single: assert property (@(posedge clk) disable iff (!rst_n)
      bit_tick |=> !bit_tick);

endmodule

// File: tb/baud_rate_gen_tb_top.sv
module baud_rate_gen_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       boot_sel = 1'b0;
   logic       mode_a = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;
   logic       os_tick, bit_tick;

   int errors = 0;
   int checks = 0;
   int cyc = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   baud_rate_gen dut_i (
      .clk(clk), .rst_n(rst_n), .boot_sel(boot_sel), .mode_a(mode_a),
      .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
      .os_tick(os_tick), .bit_tick(bit_tick));

   // {config byte, expected period in core cycles = 4*P*16*2^n}
   localparam int NV = 10;
   localparam logic [7:0] VCFG [NV] = '{8'h00, 8'h10, 8'h20, 8'h30, 8'h01,
                                         8'h05, 8'h07, 8'h32, 8'h88, 8'h4B};
   localparam int VPER [NV] = '{64, 192, 256, 832, 128,
                                2048, 8192, 3328, 64, 512};

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 190000 && !done) begin
         done = 1'b1;
         errors++; checks++;
         $display("FAIL watchdog: run did not finish, actual cycles=%0d expected below 190000", cyc);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Counts from index 0 = first negedge after the reference edge.
   // Returns the index of the first two bit ticks and the os ticks between.
   task automatic watch(input int limit, output int first, output int second,
                        output int os_cnt, output int wide);
      first = -1; second = -1; os_cnt = 0; wide = 0;
      for (int i = 0; i < limit; i++) begin
         if (first >= 0 && os_tick) os_cnt++;
         if (bit_tick) begin
            if (first < 0) first = i;
            else if (second < 0 && i == first + 1) wide = 1;
            else if (second < 0) begin second = i; break; end
         end
         @(negedge clk);
      end
   endtask

   task automatic write_cfg(input logic [7:0] v);
      @(negedge clk);
      wr_en = 1'b1; wr_data = v;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic do_reset(input logic b, input logic a);
      @(negedge clk);
      boot_sel = b; mode_a = a; rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      int f, s, o, w;
      // R1: plain reset
      do_reset(1'b0, 1'b0);
      check("R1 reset value", rd_data, 8'h00);
      watch(300, f, s, o, w);
      check("R1 reset period", s - f, 64);

      // R4 R5 R6 R7 R8 R9 R10 vector walk
      for (int k = 0; k < NV; k++) begin
         write_cfg(VCFG[k]);
         check("R3 readback", rd_data, VCFG[k]);
         watch(3 * VPER[k], f, s, o, w);
         check("R7 first tick index", f, VPER[k] - 1);
         check((VCFG[k] & 8'hC8) != 0 ? "R9 period with test bits" :
               ((VCFG[k] & 8'h30) != 0 ? "R4 prescale period" : "R5 rate period"),
               s - f, VPER[k]);
         check("R6 period", s - f, VPER[k]);
         check("R8 os ticks per bit", o, 16);
         check("R10 single-cycle tick", w, 0);
      end

      // R7: rewrite mid-period must not leave the old partial period
      write_cfg(8'h00);
      repeat (40) @(negedge clk);
      write_cfg(8'h00);
      watch(200, f, s, o, w);
      check("R7 restart mid-period", f, 63);

      // R3: no write keeps the value
      write_cfg(8'hA6);
      repeat (20) @(negedge clk);
      check("R3 hold without write", rd_data, 8'hA6);

      // R2: bootstrap preset
      do_reset(1'b1, 1'b0);
      check("R2 boot value", rd_data, 8'h33);
      watch(20000, f, s, o, w);
      check("R2 boot period", s - f, 6656);

      // R2: mode-A cancels bootstrap
      do_reset(1'b1, 1'b1);
      check("R2 mode_a cancels boot", rd_data, 8'h00);

      // R1: reset after a write returns to zero
      write_cfg(8'h37);
      do_reset(1'b0, 1'b0);
      check("R1 reset after write", rd_data, 8'h00);

      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule